// File: doc/BRIEF.md
# SD Command Line Sequencer

This block owns the single command wire of an SD or MMC card. When a command is started it sends a 48-bit frame on the wire, most significant bit first. The frame holds a zero start bit, a one transmission bit, the command index, the 32-bit argument, a CRC7 over those first 40 bits, and a one end bit. The wire moves one bit per card-clock enable tick. The block then either lets the card clock run idle for a few periods, or waits for the card to answer. An answer is either a 48-bit status response or a 136-bit register response. The block checks the answer and stores its content in four 32-bit words.

The host side sets up index, argument, response flags and a timeout, and then pulses `start`. It watches `busy`, which ends with a one-cycle `done` pulse. After that pulse it reads the response words and the three error flags. The flags keep their value until the next accepted start. Everything runs in the system clock domain. A pulse on `tick` marks each card clock period, so the same logic serves any card clock divisor.

Top module: `sdcmd_seq`

## Requirements
- R1: After a start is accepted, each of the next 48 ticks drives one frame bit on `cmd_out`, with `cmd_oe` high. The bits go out in this order: 0, 1, six index bits, 32 argument bits (each field MSB first), then seven CRC bits, then 1. The CRC uses x^7+x^3+1 with a zero initial value, taken over the first 40 bits. `cmd_out` changes only in the cycle after a tick.
- R2: With `want_resp` low, `done` rises in the cycle after the first tick that follows the end bit. If `add_pad` is also set, `done` rises after the ninth such tick instead, which gives 8 extra card clocks.
- R3: From the first tick after the end bit, and at all times while idle, `cmd_oe` is low and `cmd_out` is high.
- R4: A 48-bit response puts its 32 bits after the 8 header bits into word 0. Words 1 to 3 read zero.
- R5: A 136-bit response (`long_resp` set) puts its 120 bits after the 8 header bits into the words, with the least significant part in word 0. The top 8 bits of word 3 read zero. A long response never raises `err_crc`.
- R6: For a 48-bit response, `err_crc` is raised when response bits 7..1 differ from the CRC7 over the first 40 received bits. When `skip_crc` is set, `err_crc` stays low.
- R7: A response whose last bit is 0 raises `err_stop`.
- R8: Listening starts on the first tick after the end bit. A start bit is accepted if it appears within the first `timeout_lim`+1 listening ticks. Otherwise, on listening tick `timeout_lim`+1, the block raises `err_timeout` alone, pulses `done` and leaves the response words unchanged.
- R9: A `start` pulse while `busy` is high has no effect on the frame being sent.
- R10: `done` lasts one cycle and `busy` is low while it is high. `busy` stays high from the cycle after an accepted start until `done`. The error flags are cleared by an accepted start.
- R11: After reset, `cmd_oe`, `busy`, `done`, all flags and all response words are 0, and `cmd_out` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse per card clock period |
| start | input | 1 | Begin a command (accepted only when idle) |
| cmd_index | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| want_resp | input | 1 | Wait for and capture a response |
| long_resp | input | 1 | Response is 136 bits instead of 48 |
| skip_crc | input | 1 | Do not flag a CRC mismatch on a 48-bit response |
| add_pad | input | 1 | Add 8 card clocks after the end bit when no response is expected |
| timeout_lim | input | 16 | Listening ticks allowed before the start bit |
| cmd_in | input | 1 | Sampled command wire from the card |
| cmd_out | output | 1 | Driven command wire value |
| cmd_oe | output | 1 | Drive enable for the command wire |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |
| resp_word0 | output | 32 | Response bits, least significant word |
| resp_word1 | output | 32 | Response bits, word 1 |
| resp_word2 | output | 32 | Response bits, word 2 |
| resp_word3 | output | 32 | Response bits, most significant word |
| err_timeout | output | 1 | No start bit within the timeout |
| err_crc | output | 1 | Short response CRC mismatch |
| err_stop | output | 1 | Response end bit was 0 |

## Verification
Most internal faults reach the wire at once. A frame register loaded or shifted wrongly gives a wrong `cmd_out` on the very tick of the first bad bit, and a wrong bit counter moves the release of `cmd_oe` away from tick 48. Faults on the receive side stay hidden until the end of the response. A wrong receive counter or CRC window shows up only as a shifted `done` tick, wrong words or a false error flag. For that reason the bench checks `done`, `busy` and the line on every tick, and checks every word and flag at completion. A fault in the listening counter appears as a `done` pulse on a listening tick other than `timeout_lim`+1.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEND,
    ST_TAIL,
    ST_LISTEN,
    ST_RECV
  } seq_state_e;

  // one serial step of CRC7, generator x^7 + x^3 + 1
  function automatic logic [6:0] crc7_step(input logic [6:0] c, input logic b);
    logic fb;
    fb = b ^ c[6];
    return {c[5:3], c[2] ^ fb, c[1:0], fb};
  endfunction

endpackage

// File: rtl/sdcmd_crc7.sv
module sdcmd_crc7
  import sdcmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       en,
  input  logic       bit_in,
  output logic [6:0] crc
);

  always_ff @(posedge clk) begin
    if (rst || clr) crc <= '0;
    else if (en)    crc <= crc7_step(crc, bit_in);
  end

endmodule

// File: rtl/sdcmd_txframe.sv
module sdcmd_txframe
  import sdcmd_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int ARG_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             shift,
  input  logic [IDX_W-1:0] idx,
  input  logic [ARG_W-1:0] arg,
  output logic             bit_out
);

  localparam int BODY_W  = 2 + IDX_W + ARG_W;
  localparam int FRAME_W = BODY_W + 8;

  logic [BODY_W-1:0]  body;
  logic [FRAME_W-1:0] frame_q;

  function automatic logic [6:0] crc_over(input logic [BODY_W-1:0] v);
    logic [6:0] c;
    c = '0;
    for (int i = BODY_W - 1; i >= 0; i--) c = crc7_step(c, v[i]);
    return c;
  endfunction

  assign body = {2'b01, idx, arg};

  always_ff @(posedge clk) begin
    if (rst)        frame_q <= '1;
    else if (load)  frame_q <= {body, crc_over(body), 1'b1};
    else if (shift) frame_q <= {frame_q[FRAME_W-2:0], 1'b1};
  end

  assign bit_out = frame_q[FRAME_W-1];

endmodule

// File: rtl/sdcmd_rxcap.sv
module sdcmd_rxcap #(
  parameter int SH_W = 127
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            en,
  input  logic            bit_in,
  output logic [SH_W-1:0] sh
);

  always_ff @(posedge clk) begin
    if (rst || clr) sh <= '0;
    else if (en)    sh <= {sh[SH_W-2:0], bit_in};
  end

endmodule

// File: rtl/sdcmd_seq.sv
module sdcmd_seq
  import sdcmd_pkg::*;
#(
  parameter int TMO_W     = 16,
  parameter int IDX_W     = 6,
  parameter int ARG_W     = 32,
  parameter int LONG_BITS = 136,
  parameter int PAD_CLKS  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             start,
  input  logic [IDX_W-1:0] cmd_index,
  input  logic [ARG_W-1:0] cmd_arg,
  input  logic             want_resp,
  input  logic             long_resp,
  input  logic             skip_crc,
  input  logic             add_pad,
  input  logic [TMO_W-1:0] timeout_lim,
  input  logic             cmd_in,
  output logic             cmd_out,
  output logic             cmd_oe,
  output logic             busy,
  output logic             done,
  output logic [31:0]      resp_word0,
  output logic [31:0]      resp_word1,
  output logic [31:0]      resp_word2,
  output logic [31:0]      resp_word3,
  output logic             err_timeout,
  output logic             err_crc,
  output logic             err_stop
);

  localparam int HDR_BITS   = 8;
  localparam int SHORT_BITS = 2 + IDX_W + ARG_W + 8;
  localparam int CRC_SPAN   = SHORT_BITS - 8;
  localparam int CNT_W      = $clog2(LONG_BITS);
  localparam int SH_W       = LONG_BITS - HDR_BITS - 1;
  localparam int PAD_W      = $clog2(PAD_CLKS + 1);
  localparam int WORD_W     = 32;
  localparam int RESP_W     = 4 * WORD_W;

  seq_state_e       state;
  logic [CNT_W-1:0] bcnt;
  logic [TMO_W-1:0] wcnt, lat_tmo;
  logic [PAD_W-1:0] pcnt;
  logic             lat_resp, lat_long, lat_skip, lat_pad;
  logic [RESP_W-1:0] resp_q;

  logic             load_frame, tx_shift, tx_bit;
  logic             rx_hit, rx_en, crc_en;
  logic [6:0]       crc_calc;
  logic [SH_W-1:0]  sh;
  logic [CNT_W-1:0] last_idx;
  logic [PAD_W-1:0] pad_end;

  assign load_frame = (state == ST_IDLE) && start;
  assign tx_shift   = (state == ST_SEND) && tick;
  assign rx_hit     = (state == ST_LISTEN) && tick && !cmd_in;
  assign rx_en      = (state == ST_RECV) && tick;
  assign crc_en     = rx_en && (bcnt < CNT_W'(CRC_SPAN));
  assign last_idx   = lat_long ? CNT_W'(LONG_BITS - 1) : CNT_W'(SHORT_BITS - 1);
  assign pad_end    = lat_pad ? PAD_W'(PAD_CLKS) : '0;

  sdcmd_txframe #(.IDX_W(IDX_W), .ARG_W(ARG_W)) u_tx (
    .clk(clk), .rst(rst), .load(load_frame), .shift(tx_shift),
    .idx(cmd_index), .arg(cmd_arg), .bit_out(tx_bit)
  );

  sdcmd_crc7 u_crc (
    .clk(clk), .rst(rst), .clr(rx_hit), .en(crc_en),
    .bit_in(cmd_in), .crc(crc_calc)
  );

  sdcmd_rxcap #(.SH_W(SH_W)) u_rx (
    .clk(clk), .rst(rst), .clr(rx_hit), .en(rx_en),
    .bit_in(cmd_in), .sh(sh)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      bcnt        <= '0;
      wcnt        <= '0;
      pcnt        <= '0;
      lat_tmo     <= '0;
      lat_resp    <= 1'b0;
      lat_long    <= 1'b0;
      lat_skip    <= 1'b0;
      lat_pad     <= 1'b0;
      cmd_out     <= 1'b1;
      cmd_oe      <= 1'b0;
      done        <= 1'b0;
      err_timeout <= 1'b0;
      err_crc     <= 1'b0;
      err_stop    <= 1'b0;
      resp_q      <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            lat_resp    <= want_resp;
            lat_long    <= long_resp;
            lat_skip    <= skip_crc;
            lat_pad     <= add_pad;
            lat_tmo     <= timeout_lim;
            err_timeout <= 1'b0;
            err_crc     <= 1'b0;
            err_stop    <= 1'b0;
            bcnt        <= '0;
            state       <= ST_SEND;
          end
        end
        ST_SEND: begin
          if (tick) begin
            cmd_oe  <= 1'b1;
            cmd_out <= tx_bit;
            if (bcnt == CNT_W'(SHORT_BITS - 1)) begin
              bcnt  <= '0;
              wcnt  <= '0;
              pcnt  <= '0;
              state <= lat_resp ? ST_LISTEN : ST_TAIL;
            end else begin
              bcnt <= bcnt + 1'b1;
            end
          end
        end
        ST_TAIL: begin
          if (tick) begin
            cmd_oe  <= 1'b0;
            cmd_out <= 1'b1;
            if (pcnt == pad_end) begin
              done  <= 1'b1;
              state <= ST_IDLE;
            end else begin
              pcnt <= pcnt + 1'b1;
            end
          end
        end
        ST_LISTEN: begin
          if (tick) begin
            cmd_oe  <= 1'b0;
            cmd_out <= 1'b1;
            if (!cmd_in) begin
              bcnt  <= CNT_W'(1);
              state <= ST_RECV;
            end else if (wcnt == lat_tmo) begin
              err_timeout <= 1'b1;
              done        <= 1'b1;
              state       <= ST_IDLE;
            end else begin
              wcnt <= wcnt + 1'b1;
            end
          end
        end
        ST_RECV: begin
          if (tick) begin
            if (bcnt == last_idx) begin
              err_stop <= !cmd_in;
              err_crc  <= !lat_long && !lat_skip && (sh[6:0] != crc_calc);
              if (lat_long) resp_q <= RESP_W'(sh[SH_W-1:7]);
              else          resp_q <= RESP_W'(sh[ARG_W+6:7]);
              done  <= 1'b1;
              state <= ST_IDLE;
            end else begin
              bcnt <= bcnt + 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy       = (state != ST_IDLE);
  assign resp_word0 = resp_q[WORD_W-1:0];
  assign resp_word1 = resp_q[2*WORD_W-1:WORD_W];
  assign resp_word2 = resp_q[3*WORD_W-1:2*WORD_W];
  assign resp_word3 = resp_q[4*WORD_W-1:3*WORD_W];

  // R3: the wire is only driven during a command
  p_oe_in_cmd_r3: assert property (@(posedge clk) disable iff (rst)
    cmd_oe |-> busy);

  // R3: a released wire idles high
  p_release_high_r3: assert property (@(posedge clk) disable iff (rst)
    !cmd_oe |-> cmd_out);

  // R1: bits advance only on card clock ticks
  p_line_on_tick_r1: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cmd_out));

  // R10: completion is a single cycle and ends the busy window
  p_done_single_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_idle_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R8: a timeout reports no other fault
  p_timeout_alone_r8: assert property (@(posedge clk) disable iff (rst)
    err_timeout |-> (!err_crc && !err_stop));

  // R5: long responses never flag CRC
  p_long_no_crc_r5: assert property (@(posedge clk) disable iff (rst)
    (done && lat_long) |-> !err_crc);

endmodule

// File: tb/sdcmd_seq_tb.sv
`timescale 1ns/1ps
module sdcmd_seq_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        start = 1'b0;
  logic [5:0]  cmd_index = '0;
  logic [31:0] cmd_arg = '0;
  logic        want_resp = 1'b0, long_resp = 1'b0, skip_crc = 1'b0, add_pad = 1'b0;
  logic [15:0] timeout_lim = '0;
  logic        cmd_in = 1'b1;
  logic        cmd_out, cmd_oe, busy, done;
  logic [31:0] resp_word0, resp_word1, resp_word2, resp_word3;
  logic        err_timeout, err_crc, err_stop;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  logic [31:0] ew0 = '0, ew1 = '0, ew2 = '0, ew3 = '0;
  logic [47:0] last_cap;

  always #5 clk = ~clk;

  sdcmd_seq u_dut (
    .clk(clk), .rst(rst), .tick(tick), .start(start),
    .cmd_index(cmd_index), .cmd_arg(cmd_arg),
    .want_resp(want_resp), .long_resp(long_resp), .skip_crc(skip_crc), .add_pad(add_pad),
    .timeout_lim(timeout_lim), .cmd_in(cmd_in),
    .cmd_out(cmd_out), .cmd_oe(cmd_oe), .busy(busy), .done(done),
    .resp_word0(resp_word0), .resp_word1(resp_word1),
    .resp_word2(resp_word2), .resp_word3(resp_word3),
    .err_timeout(err_timeout), .err_crc(err_crc), .err_stop(err_stop)
  );

  task automatic chk(input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [6:0] ref_crc(input logic [39:0] v);
    logic [6:0] r;
    logic inv;
    r = '0;
    for (int i = 39; i >= 0; i--) begin
      inv = v[i] ^ r[6];
      r = {r[5:0], 1'b0};
      if (inv) r = r ^ 7'h09;
    end
    return r;
  endfunction

  task automatic run_txn(input string req, input logic [5:0] idx, input logic [31:0] arg,
                         input bit want, input bit lng, input bit skip, input bit pad,
                         input int lim, input int d, input bit corrupt, input bit badstop,
                         input logic [119:0] pay, input bit inject);
    logic [47:0]  frame;
    logic [135:0] rb;
    int  total, tend;
    bit  to;
    logic cin;
    frame = {2'b01, idx, arg, ref_crc({2'b01, idx, arg}), 1'b1};
    total = lng ? 136 : 48;
    rb = '0;
    if (lng) rb = {2'b00, 6'h3f, pay, 7'h55, !badstop};
    else rb[47:0] = {2'b00, idx, pay[31:0],
                     ref_crc({2'b00, idx, pay[31:0]}) ^ (corrupt ? 7'h01 : 7'h00), !badstop};
    to = want && (d > lim);
    if (!want)   tend = pad ? 56 : 48;
    else if (to) tend = 48 + lim;
    else         tend = 48 + d + total - 1;

    @(negedge clk);
    cmd_index = idx; cmd_arg = arg; want_resp = want; long_resp = lng;
    skip_crc = skip; add_pad = pad; timeout_lim = 16'(lim); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R10", "busy after start", busy, 1);

    for (int t = 0; t <= tend; t++) begin
      cin = 1'b1;
      if (want && !to && t >= 48 + d && t < 48 + d + total) cin = rb[total - 1 - (t - 48 - d)];
      @(negedge clk);
      start = 1'b0;
      tick = 1'b1; cmd_in = cin;
      @(negedge clk);
      tick = 1'b0;
      if (t <= 47) begin
        chk("R1", "cmd_oe while sending", cmd_oe, 1);
        chk("R1", "frame bit", cmd_out, frame[47 - t]);
        last_cap[47 - t] = cmd_out;
      end else begin
        chk("R3", "cmd_oe released", cmd_oe, 0);
        chk("R3", "line high", cmd_out, 1);
      end
      chk(want ? "R8" : "R2", "done on tick", done, (t == tend));
      chk("R10", "busy on tick", busy, (t != tend));
      @(negedge clk);
      if (inject && t == 10) begin
        start = 1'b1;
        cmd_index = idx ^ 6'h2A;
        cmd_arg = ~arg;
      end
      chk("R10", "done single pulse", done, 0);
    end
    start = 1'b0;

    if (want && !to) begin
      if (lng) {ew3, ew2, ew1, ew0} = {8'h00, pay};
      else     {ew3, ew2, ew1, ew0} = {96'h0, pay[31:0]};
    end
    chk("R10", "busy after done", busy, 0);
    chk("R8", "err_timeout", err_timeout, to);
    chk("R6", "err_crc", err_crc, want && !to && !lng && !skip && corrupt);
    chk("R7", "err_stop", err_stop, want && !to && badstop);
    chk(lng ? "R5" : "R4", "word0", resp_word0, ew0);
    chk(lng ? "R5" : "R4", "word1", resp_word1, ew1);
    chk(lng ? "R5" : "R4", "word2", resp_word2, ew2);
    chk(lng ? "R5" : "R4", "word3", resp_word3, ew3);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk("R11", "cmd_oe", cmd_oe, 0);
    chk("R11", "cmd_out", cmd_out, 1);
    chk("R11", "busy", busy, 0);
    chk("R11", "done", done, 0);
    chk("R11", "flags", {err_timeout, err_crc, err_stop}, 0);
    chk("R11", "words", {resp_word3, resp_word2, resp_word1, resp_word0}, 0);

    // R1 R2: reset command, no response, no padding; CRC field must be 0x4A
    run_txn("R2", 6'd0, 32'h0, 0, 0, 0, 0, 10, 0, 0, 0, '0, 0);
    chk("R1", "CRC of index 0", last_cap[7:1], 7'h4A);

    // R4: short response; CRC of this command must be 0x43
    run_txn("R4", 6'd8, 32'h0000_01AA, 1, 0, 0, 0, 100, 2, 0, 0, 120'h1AA, 0);
    chk("R1", "CRC of index 8", last_cap[7:1], 7'h43);

    // R2: eight trailing clocks
    run_txn("R2", 6'd7, 32'hDEAD_BEEF, 0, 0, 0, 1, 10, 0, 0, 0, '0, 0);

    // R6: corrupted CRC flagged, then suppressed by skip_crc
    run_txn("R6", 6'd13, 32'h1234_5678, 1, 0, 0, 0, 50, 4, 1, 0, 120'hCAFE_F00D, 0);
    run_txn("R6", 6'd41, 32'h0, 1, 0, 1, 0, 50, 1, 1, 0, 120'h00FF_8000, 0);

    // R5: long response, line CRC not checked
    run_txn("R5", 6'd2, 32'h0, 1, 1, 0, 0, 64, 3,
            0, 0, 120'h0123_4567_89AB_CDEF_FEDC_BA98_7654_32, 0);

    // R7: bad end bit
    run_txn("R7", 6'd55, 32'h0F0F_0F0F, 1, 0, 0, 0, 20, 2, 0, 1, 120'h8765_4321, 0);

    // R8: timeout, boundary accept, zero limit
    run_txn("R8", 6'd17, 32'h4, 1, 0, 0, 0, 3, 5, 0, 0, 120'h1111_2222, 0);
    run_txn("R8", 6'd17, 32'h5, 1, 0, 0, 0, 3, 3, 0, 0, 120'h3333_4444, 0);
    run_txn("R8", 6'd18, 32'h6, 1, 0, 0, 0, 0, 1, 0, 0, 120'h5555_6666, 0);

    // R9: start pulse in the middle of a command is ignored
    run_txn("R9", 6'd24, 32'hA5A5_5A5A, 1, 0, 0, 0, 30, 2, 0, 0, 120'h7777_8888, 1);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule